// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter, four bits wide by default, that wraps from all ones back to zero. It can be preset from a parallel input, and it has two count enables and a carry output. Several copies can therefore be chained into one wide synchronous counter, or used as a programmable divider that reloads a start value whenever the carry fires.

The carry output depends on only one of the two enables, the chain enable. In a chain, each stage's carry drives the next stage's chain enable, and the shared count enable reaches every stage directly. A stage only has to wait for the carry of the stage below it, and the fast count enable still reaches every stage in one step. A build-time parameter selects whether the active-low reset clears the count at once, without the clock, or on the next rising clock edge.

Top module: `pbin_counter`

## Requirements
- R1: From the all-ones value (15 at the default width), a counting edge returns `count` to 0; the sequence otherwise runs upward in steps of one.
- R2: On a rising edge the controls take effect in a fixed order: reset first, then load, then count, then hold. The first reset edge and the release of reset both leave `count` at 0 and `carry_out` low.
- R3: With `RESET_ASYNC`=1, a low `rst_n` drives `count` and `carry_out` to 0 at once, with no clock edge and whatever the other inputs are.
- R4: With `RESET_ASYNC`=0, a low `rst_n` leaves `count` unchanged until the next rising edge and then clears it, even when a load or a count is requested on the same edge.
- R5: With reset inactive, `ld_n` low loads `ld_val` into `count` on the next rising edge, whatever the values of `cnt_en` and `chain_en`.
- R6: With `rst_n` and `ld_n` high, `count` increments on a rising edge when `cnt_en` and `chain_en` are both high.
- R7: With `rst_n` and `ld_n` high, `count` keeps its value on a rising edge when either `cnt_en` or `chain_en` is low.
- R8: `carry_out` is high exactly when `count` is all ones and `chain_en` is high. It follows `chain_en` without waiting for a clock edge and does not depend on `cnt_en`.
- R9: Three stages whose `carry_out` feeds the next stage's `chain_en`, with shared clock and `cnt_en`, count as one 12-bit counter. The chain passes from 4095 to 0, and its last carry is high only at 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes except the asynchronous clear happen on its rising edge |
| rst_n | input | 1 | Active-low clear, asynchronous or synchronous according to `RESET_ASYNC` |
| ld_n | input | 1 | Active-low parallel load request |
| cnt_en | input | 1 | Count enable shared by every stage of a chain |
| chain_en | input | 1 | Count enable that also gates `carry_out`; fed from the carry of the stage below |
| ld_val | input | WIDTH | Value loaded into the count |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when the count is all ones and `chain_en` is high |

## Verification
Loads are applied under every combination of the two enables, to show that a load does not care about counting. Counting runs through the all-ones value, and each enable is lowered on its own to separate the hold cases from one another. A reset is raised while a load and a count are both requested. Its effect is sampled before the next edge to tell the immediate clear from the edge-timed one, and again after the edge to confirm that the clear wins. A three-stage chain is run through its full 4096-state cycle, and a random mix of all controls, load and count often requested together, is compared each cycle against a model in the bench for both reset styles.

// File: rtl/pbin_pkg.sv
package pbin_pkg;

    // Action selected for the next rising edge, highest priority first.
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/pbin_mode_dec.sv
module pbin_mode_dec
    import pbin_pkg::*;
#(
    parameter bit RESET_ASYNC = 1'b1
) (
    input  logic      rst_n,
    input  logic      ld_n,
    input  logic      cnt_en,
    input  logic      chain_en,
    output cnt_mode_e mode
);

    // The edge-timed clear only exists in the synchronous style; the
    // asynchronous style clears through the register reset instead.
    localparam bit EDGE_CLEAR = !RESET_ASYNC;

    logic clear_req;
    logic run_req;

    assign clear_req = EDGE_CLEAR && !rst_n;
    assign run_req   = cnt_en && chain_en;

    always_comb begin
        if (clear_req) begin
            mode = MODE_CLEAR;
        end else if (!ld_n) begin
            mode = MODE_LOAD;
        end else if (run_req) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/pbin_state.sv
module pbin_state
    import pbin_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             arst_n,
    input  cnt_mode_e        mode,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] cnt_q_o
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d;
    cnt_state_t state_q;

    always_comb begin
        state_d = state_q;
        unique case (mode)
            MODE_CLEAR: state_d.cnt = '0;
            MODE_LOAD:  state_d.cnt = ld_val;
            MODE_COUNT: state_d.cnt = state_q.cnt + STEP;
            MODE_HOLD:  state_d.cnt = state_q.cnt;
            default:    state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_q_o = state_q.cnt;

endmodule

// File: rtl/pbin_carry.sv
module pbin_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic             chain_en,
    output logic             carry
);

    logic at_top;

    // Reduction over each bit; generate keeps the structure per bit.
    logic [WIDTH-1:0] ones;
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            if (b == 0) begin : g_first
                assign ones[b] = cnt[b];
            end else begin : g_next
                assign ones[b] = ones[b-1] & cnt[b];
            end
        end
    endgenerate

    assign at_top = ones[WIDTH-1];
    assign carry  = at_top & chain_en;

endmodule

// File: rtl/pbin_counter.sv
module pbin_counter
    import pbin_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit RESET_ASYNC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);

    cnt_mode_e        mode;
    logic             arst_n;
    logic [WIDTH-1:0] cnt_q;

    // Register reset is only wired in the asynchronous style.
    generate
        if (RESET_ASYNC) begin : g_arst
            assign arst_n = rst_n;
        end else begin : g_srst
            assign arst_n = 1'b1;
        end
    endgenerate

    pbin_mode_dec #(
        .RESET_ASYNC (RESET_ASYNC)
    ) u_dec (
        .rst_n    (rst_n),
        .ld_n     (ld_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .mode     (mode)
    );

    pbin_state #(
        .WIDTH (WIDTH)
    ) u_state (
        .clk     (clk),
        .arst_n  (arst_n),
        .mode    (mode),
        .ld_val  (ld_val),
        .cnt_q_o (cnt_q)
    );

    pbin_carry #(
        .WIDTH (WIDTH)
    ) u_carry (
        .cnt      (cnt_q),
        .chain_en (chain_en),
        .carry    (carry_out)
    );

    assign count = cnt_q;

endmodule

// File: rtl/pbin_checker.sv
module pbin_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_n,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] ld_val,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // R1: all ones wraps to zero on a counting edge
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && cnt_en && chain_en && count == TOP) |=> (count == '0));

    // R2: leaving reset finds the count cleared
    p_release_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0 && !carry_out));

    // R5: load takes the parallel value whatever the enables
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> (count == $past(ld_val)));

    // R6: both enables high advance by one
    p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && cnt_en && chain_en) |=> (count == WIDTH'($past(count) + 1'b1)));

    // R7: either enable low holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n && !(cnt_en && chain_en)) |=> $stable(count));

    // R8: carry needs the chain enable
    p_carry_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |-> !carry_out);

    // R8: carry raised at the top value with the chain enable high
    p_carry_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en && count == TOP) |-> carry_out);

    // R8: carry never without the top value
    p_carry_only_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (count == TOP));

endmodule

bind pbin_counter pbin_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_n      (ld_n),
    .cnt_en    (cnt_en),
    .chain_en  (chain_en),
    .ld_val    (ld_val),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/pbin_counter_test.sv
`timescale 1ns/1ps

module pbin_chain #(
    parameter int STAGES = 3,
    parameter int WIDTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_n,
    input  logic                    cnt_en,
    input  logic                    chain_en,
    input  logic [STAGES*WIDTH-1:0] ld_val,
    output logic [STAGES*WIDTH-1:0] count,
    output logic                    carry_out
);
    logic [STAGES:0] link;
    assign link[0] = chain_en;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            pbin_counter #(.WIDTH(WIDTH), .RESET_ASYNC(1'b1)) u_st (
                .clk       (clk),
                .rst_n     (rst_n),
                .ld_n      (ld_n),
                .cnt_en    (cnt_en),
                .chain_en  (link[s]),
                .ld_val    (ld_val[s*WIDTH +: WIDTH]),
                .count     (count[s*WIDTH +: WIDTH]),
                .carry_out (link[s+1])
            );
        end
    endgenerate

    assign carry_out = link[STAGES];
endmodule

module pbin_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_n = 1'b1;
    logic        cnt_en = 1'b0;
    logic        chain_en = 1'b0;
    logic [3:0]  ld_val = 4'd0;
    logic [3:0]  cnt_a, cnt_s;
    logic        cy_a, cy_s;

    logic        c_ld_n = 1'b1;
    logic        c_cnt_en = 1'b0;
    logic        c_chain_en = 1'b0;
    logic [11:0] c_val = 12'd0;
    logic [11:0] c_cnt;
    logic        c_cy;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pbin_counter #(.WIDTH(4), .RESET_ASYNC(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .ld_val(ld_val), .count(cnt_a), .carry_out(cy_a)
    );

    pbin_counter #(.WIDTH(4), .RESET_ASYNC(1'b0)) uut_sync (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .ld_val(ld_val), .count(cnt_s), .carry_out(cy_s)
    );

    pbin_chain #(.STAGES(3), .WIDTH(4)) u_chain (
        .clk(clk), .rst_n(rst_n), .ld_n(c_ld_n), .cnt_en(c_cnt_en),
        .chain_en(c_chain_en), .ld_val(c_val), .count(c_cnt), .carry_out(c_cy)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait for the next rising edge and step just past it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_both(input string req, input logic [3:0] exp_cnt,
                            input logic exp_cy);
        chk(req, "async count", {28'd0, cnt_a}, {28'd0, exp_cnt});
        chk(req, "sync count", {28'd0, cnt_s}, {28'd0, exp_cnt});
        chk(req, "async carry", {31'd0, cy_a}, {31'd0, exp_cy});
        chk(req, "sync carry", {31'd0, cy_s}, {31'd0, exp_cy});
    endtask

    task automatic do_load(input logic [3:0] v, input logic ep, input logic et);
        ld_n = 1'b0; ld_val = v; cnt_en = ep; chain_en = et;
        tick();
        ld_n = 1'b1;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) tick();
        chk_both("R2", 4'd0, 1'b0);
        rst_n = 1'b1;
        tick();
        chk_both("R2", 4'd0, 1'b0);
    endtask

    task automatic t_load();
        logic [3:0] vals [4] = '{4'd9, 4'd0, 4'd15, 4'd6};
        for (int i = 0; i < 4; i++) begin
            logic ep = i[0];
            logic et = i[1];
            do_load(vals[i], ep, et);
            // R5: loaded value regardless of enables
            chk_both("R5", vals[i], (vals[i] == 4'd15) && et);
        end
    endtask

    task automatic t_count_wrap();
        logic [3:0] exp;
        do_load(4'd12, 1'b0, 1'b0);
        cnt_en = 1'b1; chain_en = 1'b1;
        exp = 4'd12;
        for (int i = 0; i < 5; i++) begin
            tick();
            exp = exp + 4'd1;
            // R6 increments; R1 covers the 15 -> 0 step
            chk_both(exp == 4'd0 ? "R1" : "R6", exp, exp == 4'd15);
        end
        cnt_en = 1'b0; chain_en = 1'b0;
    endtask

    task automatic t_hold();
        do_load(4'd5, 1'b0, 1'b0);
        cnt_en = 1'b0; chain_en = 1'b1;
        repeat (2) tick();
        chk_both("R7", 4'd5, 1'b0);
        cnt_en = 1'b1; chain_en = 1'b0;
        tick();
        chk_both("R7", 4'd5, 1'b0);
        cnt_en = 1'b0; chain_en = 1'b0;
        tick();
        chk_both("R7", 4'd5, 1'b0);
    endtask

    task automatic t_carry();
        do_load(4'd15, 1'b0, 1'b0);
        chk_both("R8", 4'd15, 1'b0);
        chain_en = 1'b1;
        #0.5;
        chk_both("R8", 4'd15, 1'b1);
        cnt_en = 1'b1;
        #0.3;
        chk_both("R8", 4'd15, 1'b1);
        cnt_en = 1'b0;
        chain_en = 1'b0;
        #0.3;
        chk_both("R8", 4'd15, 1'b0);
        do_load(4'd14, 1'b0, 1'b1);
        chk_both("R8", 4'd14, 1'b0);
        chain_en = 1'b0;
    endtask

    task automatic t_precedence();
        do_load(4'd10, 1'b0, 1'b0);
        ld_n = 1'b0; ld_val = 4'd3; cnt_en = 1'b1; chain_en = 1'b1;
        tick();
        // R2: load outranks count
        chk_both("R2", 4'd3, 1'b0);
        ld_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
    endtask

    task automatic t_reset_styles();
        do_load(4'd15, 1'b0, 1'b1);
        chk_both("R8", 4'd15, 1'b1);
        ld_n = 1'b0; ld_val = 4'd7; cnt_en = 1'b1; chain_en = 1'b1;
        rst_n = 1'b0;
        #1;
        // R3: immediate clear, no edge yet
        chk("R3", "async count", {28'd0, cnt_a}, 32'd0);
        chk("R3", "async carry", {31'd0, cy_a}, 32'd0);
        // R4: edge-timed style still holds its value
        chk("R4", "sync count", {28'd0, cnt_s}, 32'd15);
        chk("R4", "sync carry", {31'd0, cy_s}, 32'd1);
        tick();
        // R4: clear beats load and count on the edge
        chk_both("R4", 4'd0, 1'b0);
        rst_n = 1'b1; ld_n = 1'b1; cnt_en = 1'b0;
        tick();
        chk_both("R2", 4'd0, 1'b0);
        chain_en = 1'b0;
    endtask

    task automatic t_chain();
        int bad = 0;
        logic [11:0] exp;
        c_ld_n = 1'b0; c_val = 12'd0;
        tick();
        c_ld_n = 1'b1;
        chk("R9", "chain load", {20'd0, c_cnt}, 32'd0);
        c_cnt_en = 1'b1; c_chain_en = 1'b1;
        exp = 12'd0;
        for (int i = 1; i <= 4096; i++) begin
            tick();
            exp = exp + 12'd1;
            if (c_cnt !== exp || c_cy !== (exp == 12'hFFF)) bad++;
            if (exp == 12'hFFF) begin
                chk("R9", "chain at 4095", {20'd0, c_cnt}, 32'd4095);
                chk("R9", "chain carry at 4095", {31'd0, c_cy}, 32'd1);
            end
        end
        chk("R9", "chain after wrap", {20'd0, c_cnt}, 32'd0);
        chk("R9", "chain carry after wrap", {31'd0, c_cy}, 32'd0);
        chk("R9", "chain step mismatches", bad, 32'd0);
        c_ld_n = 1'b0; c_val = 12'd255;
        tick();
        c_ld_n = 1'b1;
        c_chain_en = 1'b0;
        tick();
        chk("R9", "chain hold on low chain enable", {20'd0, c_cnt}, 32'd255);
        c_chain_en = 1'b1;
        tick();
        chk("R9", "chain carries into stage 2", {20'd0, c_cnt}, 32'd256);
        c_cnt_en = 1'b0; c_chain_en = 1'b0;
    endtask

    task automatic t_random();
        logic [3:0] exp = cnt_a;
        int bad = 0;
        for (int i = 0; i < 600; i++) begin
            rst_n    = ($urandom_range(15) != 0);
            ld_n     = ($urandom_range(3) != 0);
            cnt_en   = $urandom_range(1);
            chain_en = $urandom_range(1);
            ld_val   = 4'($urandom_range(15));
            if (!rst_n)               exp = 4'd0;
            else if (!ld_n)           exp = ld_val;
            else if (cnt_en && chain_en) exp = exp + 4'd1;
            tick();
            if (cnt_a !== exp || cnt_s !== exp ||
                cy_a !== (exp == 4'd15 && chain_en) ||
                cy_s !== (exp == 4'd15 && chain_en)) begin
                bad++;
                $display("FAIL R2 random step %0d: actual %0d/%0d expected %0d",
                         i, cnt_a, cnt_s, exp);
            end
        end
        // Random mix covers R5, R6, R7 and R2 together
        chk("R6", "random mismatches", bad, 32'd0);
        rst_n = 1'b1; ld_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0;
    endtask

    initial begin
        #1;
        t_reset_state();
        t_load();
        t_count_wrap();
        t_hold();
        t_carry();
        t_precedence();
        t_reset_styles();
        t_chain();
        t_random();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule